// File: doc/BRIEF.md
# Dual-Core Shared Memory Mailbox

This block links a host microcontroller and a DSP that share one clock. Each processor has its own synchronous bus port. One port input picks between two regions: a shared word memory that both sides read and write, and a small set of message registers. The shared memory holds 1024 words of 16 bits by default.

Messaging works apart from the memory. Each direction has a single message word, together with a full flag that the receiver sees and an empty flag that the sender sees. The receiver can poll its status word. It can also set an enable bit so that it gets a level interrupt while a message is waiting. If both sides write the same memory word in the same cycle, the host's data is kept and the DSP is told through a sticky status bit. A message sent while the previous one is still unread is dropped, and the sender is told through a sticky overrun bit.

Top module: `dual_core_mailbox`

## Requirements
- R1: With the region select low, either port can write any memory word and read it back. Read data shows on that port's rdata in the cycle after the address is presented, on both ports.
- R2: If both ports write the same memory word in one cycle, the host data is stored. The DSP status bit 3 (collision) then goes to 1 and stays there until the DSP writes status with bit 3 set. Writes to different words in one cycle both land and set no collision.
- R3: A read of a word that the other port writes in the same cycle returns the word's previous contents.
- R4: Message register offsets are selected by address bits [1:0]: 0 transmit, 1 receive, 2 status, 3 control. A write to transmit while the direction is empty stores the word. It sets the receiver's status bit 0 (message waiting) and clears the sender's status bit 1 (transmit empty). The receiver's read of offset 1 returns that word.
- R5: A receiver read of offset 1 while a message waits clears the receiver's bit 0 and sets the sender's bit 1 again.
- R6: A transmit write while the direction is full is dropped, and the held word stays unchanged. It sets the sender's status bit 2 (overrun), which stays until the sender writes status with bit 2 set.
- R7: A side's interrupt is high exactly while a message waits for that side and its control bit 0 (interrupt enable) is set.
- R8: A receive read while nothing waits changes no flag, and the held word stays unchanged.
- R9: After reset, both status words read 0x0002, both control words read 0, and both interrupts are low.
- R10: The two directions are independent. Traffic in one direction leaves the other direction's flags untouched, and both directions may be filled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_en | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_msg | input | 1 | Host region select: 1 message registers, 0 memory |
| h_addr | input | AW | Host word address (bits [1:0] pick the register) |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, one cycle after the address |
| h_irq | output | 1 | Host message interrupt |
| d_en | input | 1 | DSP access strobe |
| d_we | input | 1 | DSP write (1) or read (0) |
| d_msg | input | 1 | DSP region select |
| d_addr | input | AW | DSP word address |
| d_wdata | input | DW | DSP write data |
| d_rdata | output | DW | DSP read data, one cycle after the address |
| d_irq | output | 1 | DSP message interrupt |

## Verification
The bench builds the block with 16-bit words and a memory depth of 64. This keeps every word within reach, so the whole array is filled from one side and swept from the other, including the last address. The 16-bit width keeps the status and control layout the same as the default build. A narrow depth does not change the collision, read-old-data or message flag logic, so those corner cases are covered just as they would be in the full-size build.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // register offsets inside the message region, taken from address bits [1:0]
   localparam logic [1:0] OFF_TX   = 2'd0;
   localparam logic [1:0] OFF_RX   = 2'd1;
   localparam logic [1:0] OFF_STAT = 2'd2;
   localparam logic [1:0] OFF_CTRL = 2'd3;

   // status word bit positions
   localparam int ST_RXF = 0;
   localparam int ST_TXE = 1;
   localparam int ST_OVR = 2;
   localparam int ST_COL = 3;
   localparam int ST_W   = 4;

   // control word bit positions
   localparam int CT_IE  = 0;

   localparam int SIDE_HOST = 0;
   localparam int SIDE_DSP  = 1;
   localparam int N_SIDES   = 2;
endpackage

// File: rtl/mbx_shared_ram.sv
module mbx_shared_ram #(
   parameter int DW    = 16,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_en,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   input  logic          b_en,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   output logic [DW-1:0] b_rdata,
   output logic          collide
);
   logic [DW-1:0] mem [DEPTH];
   logic          a_wr, b_wr, b_wr_ok;

   assign a_wr    = a_en & a_we;
   assign b_wr    = b_en & b_we;
   assign collide = a_wr & b_wr & (a_addr == b_addr);
   assign b_wr_ok = b_wr & ~collide;

   always_ff @(posedge clk) begin
      if (a_wr)    mem[a_addr] <= a_wdata;
      if (b_wr_ok) mem[b_addr] <= b_wdata;
   end

   always_ff @(posedge clk) begin
      if (a_en && !a_we) a_rdata <= mem[a_addr];
      if (b_en && !b_we) b_rdata <= mem[b_addr];
   end

   // port a (host) keeps its data on a same-word write clash
   p_host_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && b_wr && a_addr == b_addr) |=> mem[$past(a_addr)] == $past(a_wdata));

   // read of a word written by the other port returns the old contents
   p_read_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en && !b_we && a_wr && a_addr == b_addr) |=> b_rdata == $past(mem[b_addr]));
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   input  logic          ovr_clr,
   output logic [DW-1:0] data,
   output logic          full,
   output logic          overrun
);
   logic [DW-1:0] data_q;
   logic          full_q, ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (wr && !full_q) begin
            data_q <= wdata;
            full_q <= 1'b1;
         end else if (rd && full_q) begin
            full_q <= 1'b0;
         end
         if (wr && full_q)  ovr_q <= 1'b1;
         else if (ovr_clr)  ovr_q <= 1'b0;
      end
   end

   assign data    = data_q;
   assign full    = full_q;
   assign overrun = ovr_q;

   p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !full_q) |=> (full_q && data_q == $past(wdata)));

   p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && full_q) |=> !full_q);

   p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && full_q) |=> (ovr_q && $stable(data_q)));

   p_idle_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !full_q && !wr) |=> (!full_q && $stable(data_q)));
endmodule

// File: rtl/dual_core_mailbox.sv
module dual_core_mailbox #(
   parameter int DW    = 16,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_en,
   input  logic          h_we,
   input  logic          h_msg,
   input  logic [AW-1:0] h_addr,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_rdata,
   output logic          h_irq,
   input  logic          d_en,
   input  logic          d_we,
   input  logic          d_msg,
   input  logic [AW-1:0] d_addr,
   input  logic [DW-1:0] d_wdata,
   output logic [DW-1:0] d_rdata,
   output logic          d_irq
);
   import mbx_pkg::*;

   if (DW < ST_W) begin : g_bad_dw
      $error("DW must hold the status word");
   end
   if (DEPTH < 4 || DEPTH != (1 << AW)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end

   logic [N_SIDES-1:0] en, we, msg;
   logic [AW-1:0]      addr   [N_SIDES];
   logic [DW-1:0]      wdata  [N_SIDES];
   logic [DW-1:0]      rdata  [N_SIDES];
   logic [DW-1:0]      ram_rd [N_SIDES];
   logic [DW-1:0]      cdata  [N_SIDES];
   logic [N_SIDES-1:0] full_w, ovr_w, tx_wr, rx_rd, stat_wr, irq_w;
   logic               collide;

   assign en[SIDE_HOST]    = h_en;
   assign we[SIDE_HOST]    = h_we;
   assign msg[SIDE_HOST]   = h_msg;
   assign addr[SIDE_HOST]  = h_addr;
   assign wdata[SIDE_HOST] = h_wdata;
   assign en[SIDE_DSP]     = d_en;
   assign we[SIDE_DSP]     = d_we;
   assign msg[SIDE_DSP]    = d_msg;
   assign addr[SIDE_DSP]   = d_addr;
   assign wdata[SIDE_DSP]  = d_wdata;

   assign h_rdata = rdata[SIDE_HOST];
   assign d_rdata = rdata[SIDE_DSP];
   assign h_irq   = irq_w[SIDE_HOST];
   assign d_irq   = irq_w[SIDE_DSP];

   mbx_shared_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_en    (en[SIDE_HOST] & ~msg[SIDE_HOST]),
      .a_we    (we[SIDE_HOST]),
      .a_addr  (addr[SIDE_HOST]),
      .a_wdata (wdata[SIDE_HOST]),
      .a_rdata (ram_rd[SIDE_HOST]),
      .b_en    (en[SIDE_DSP] & ~msg[SIDE_DSP]),
      .b_we    (we[SIDE_DSP]),
      .b_addr  (addr[SIDE_DSP]),
      .b_wdata (wdata[SIDE_DSP]),
      .b_rdata (ram_rd[SIDE_DSP]),
      .collide (collide)
   );

   // channel c carries messages sent by side c to the opposite side
   for (genvar c = 0; c < N_SIDES; c++) begin : g_chan
      localparam int RX = N_SIDES - 1 - c;
      assign tx_wr[c] = en[c] & we[c] & msg[c] & (addr[c][1:0] == OFF_TX);
      assign rx_rd[c] = en[RX] & ~we[RX] & msg[RX] & (addr[RX][1:0] == OFF_RX);

      mbx_channel #(.DW(DW)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (tx_wr[c]),
         .wdata   (wdata[c]),
         .rd      (rx_rd[c]),
         .ovr_clr (stat_wr[c] & wdata[c][ST_OVR]),
         .data    (cdata[c]),
         .full    (full_w[c]),
         .overrun (ovr_w[c])
      );
   end

   for (genvar s = 0; s < N_SIDES; s++) begin : g_side
      localparam int PEER = N_SIDES - 1 - s;
      logic          ie_q, col_q, msg_q;
      logic [DW-1:0] reg_q, reg_mux;
      logic [ST_W-1:0] stat;
      logic          rd_acc, ctrl_wr;

      assign rd_acc     = en[s] & ~we[s];
      assign stat_wr[s] = en[s] & we[s] & msg[s] & (addr[s][1:0] == OFF_STAT);
      assign ctrl_wr    = en[s] & we[s] & msg[s] & (addr[s][1:0] == OFF_CTRL);

      // only the losing (DSP) port records collisions
      if (s == SIDE_DSP) begin : g_col
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          col_q <= 1'b0;
            else if (collide)                    col_q <= 1'b1;
            else if (stat_wr[s] && wdata[s][ST_COL]) col_q <= 1'b0;
         end
         p_col_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            collide |=> col_q);
      end else begin : g_nocol
         assign col_q = 1'b0;
      end

      assign stat = {col_q, ovr_w[s], ~full_w[s], full_w[PEER]};

      always_comb begin
         reg_mux = '0;
         case (addr[s][1:0])
            OFF_RX:   reg_mux = cdata[PEER];
            OFF_STAT: reg_mux[ST_W-1:0] = stat;
            OFF_CTRL: reg_mux[CT_IE] = ie_q;
            default:  reg_mux = '0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ie_q  <= 1'b0;
            msg_q <= 1'b0;
            reg_q <= '0;
         end else begin
            if (ctrl_wr) ie_q <= wdata[s][CT_IE];
            if (rd_acc) begin
               msg_q <= msg[s];
               if (msg[s]) reg_q <= reg_mux;
            end
         end
      end

      assign rdata[s] = msg_q ? reg_q : ram_rd[s];
      assign irq_w[s] = full_w[PEER] & ie_q;

      p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!ie_q || !full_w[PEER]) |-> !irq_w[s]);
   end
endmodule

// File: tb/dual_core_mailbox_tb.sv
module dual_core_mailbox_tb_top;
   localparam int DW    = 16;
   localparam int DEPTH = 64;
   localparam int AW    = $clog2(DEPTH);
   localparam logic [AW-1:0] A_TX = AW'(0), A_RX = AW'(1), A_ST = AW'(2), A_CT = AW'(3);

   logic clk = 1'b0, rst_n = 1'b0;
   logic h_en = 0, h_we = 0, h_msg = 0, d_en = 0, d_we = 0, d_msg = 0;
   logic [AW-1:0] h_addr = '0, d_addr = '0;
   logic [DW-1:0] h_wdata = '0, d_wdata = '0;
   logic [DW-1:0] h_rdata, d_rdata;
   logic h_irq, d_irq;
   logic iss_h = 0, iss_d = 0, mon_h, mon_d;
   int checks = 0, errors = 0;
   logic [DW-1:0] qv_h[$], qv_d[$];
   string qr_h[$], qr_d[$];

   always #10 clk = ~clk;

   dual_core_mailbox #(.DW(DW), .DEPTH(DEPTH)) dut_i (.*);

   function automatic logic [DW-1:0] pat(int i);
      return 16'hA500 + 16'(i * 3);
   endfunction

   task automatic cmp(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus cycle on both ports; read expectations pushed by caller
   task automatic cyc(logic he, logic hw, logic hm, logic [AW-1:0] ha, logic [DW-1:0] hd,
                      logic de, logic dw, logic dm, logic [AW-1:0] da, logic [DW-1:0] dd);
      @(negedge clk);
      h_en = he; h_we = hw; h_msg = hm; h_addr = ha; h_wdata = hd;
      d_en = de; d_we = dw; d_msg = dm; d_addr = da; d_wdata = dd;
      iss_h = he & ~hw;
      iss_d = de & ~dw;
   endtask

   task automatic idle();
      cyc(0, 0, 0, '0, '0, 0, 0, 0, '0, '0);
   endtask
   task automatic hw(logic m, logic [AW-1:0] a, logic [DW-1:0] v);
      cyc(1, 1, m, a, v, 0, 0, 0, '0, '0);
   endtask
   task automatic dw(logic m, logic [AW-1:0] a, logic [DW-1:0] v);
      cyc(0, 0, 0, '0, '0, 1, 1, m, a, v);
   endtask
   task automatic hr(logic m, logic [AW-1:0] a, logic [DW-1:0] e, string req);
      qv_h.push_back(e); qr_h.push_back(req);
      cyc(1, 0, m, a, '0, 0, 0, 0, '0, '0);
   endtask
   task automatic dr(logic m, logic [AW-1:0] a, logic [DW-1:0] e, string req);
      qv_d.push_back(e); qr_d.push_back(req);
      cyc(0, 0, 0, '0, '0, 1, 0, m, a, '0);
   endtask

   // monitor: scoreboard pop one cycle after each issued read
   initial begin
      forever begin
         @(posedge clk);
         mon_h = iss_h;
         mon_d = iss_d;
         #5;
         if (mon_h) begin
            if (qv_h.size() == 0) cmp("host-queue", h_rdata, 'x);
            else cmp(qr_h.pop_front(), h_rdata, qv_h.pop_front());
         end
         if (mon_d) begin
            if (qv_d.size() == 0) cmp("dsp-queue", d_rdata, 'x);
            else cmp(qr_d.pop_front(), d_rdata, qv_d.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      idle();
      cmp("R9 h_irq", {15'd0, h_irq}, 16'd0);
      cmp("R9 d_irq", {15'd0, d_irq}, 16'd0);
      hr(1, A_ST, 16'h0002, "R9 host status");
      dr(1, A_ST, 16'h0002, "R9 dsp status");
      hr(1, A_CT, 16'h0000, "R9 host control");

      // R1: host fills memory, DSP sweeps it back to back
      for (int i = 0; i < DEPTH; i++) hw(0, AW'(i), pat(i));
      for (int i = 0; i < DEPTH; i++) dr(0, AW'(i), pat(i), "R1 dsp sweep");
      dw(0, AW'(5), 16'h1234);
      hr(0, AW'(5), 16'h1234, "R1 host reads dsp word");
      qv_h.push_back(pat(DEPTH-1)); qr_h.push_back("R1 dual read");
      qv_d.push_back(pat(7));       qr_d.push_back("R1 dual read");
      cyc(1, 0, 0, AW'(DEPTH-1), '0, 1, 0, 0, AW'(7), '0);

      // R2: same-word clash, host wins, DSP collision sticky
      cyc(1, 1, 0, AW'(10), 16'hAAAA, 1, 1, 0, AW'(10), 16'h5555);
      dr(0, AW'(10), 16'hAAAA, "R2 host data kept");
      dr(1, A_ST, 16'h000A, "R2 collision set");
      hr(1, A_ST, 16'h0002, "R2 host unaffected");
      idle();
      dr(1, A_ST, 16'h000A, "R2 collision sticky");
      dw(1, A_ST, 16'h0008);
      dr(1, A_ST, 16'h0002, "R2 collision cleared");
      cyc(1, 1, 0, AW'(11), 16'h0B0B, 1, 1, 0, AW'(12), 16'h0C0C);
      hr(0, AW'(12), 16'h0C0C, "R2 distinct words");
      dr(0, AW'(11), 16'h0B0B, "R2 distinct words");
      dr(1, A_ST, 16'h0002, "R2 no collision");

      // R3: read-old on cross-port write
      qv_d.push_back(pat(20)); qr_d.push_back("R3 old data");
      cyc(1, 1, 0, AW'(20), 16'hBEEF, 1, 0, 0, AW'(20), '0);
      dr(0, AW'(20), 16'hBEEF, "R3 new data after");

      // R4 / R5 / R7: host -> dsp with DSP interrupt enabled
      dw(1, A_CT, 16'h0001);
      hw(1, A_TX, 16'hC0DE);
      idle();
      cmp("R7 d_irq high", {15'd0, d_irq}, 16'd1);
      cmp("R7 h_irq low", {15'd0, h_irq}, 16'd0);
      dr(1, A_ST, 16'h0003, "R4 dsp waiting");
      hr(1, A_ST, 16'h0000, "R4 host tx busy");
      dr(1, A_RX, 16'hC0DE, "R4 message word");
      dr(1, A_ST, 16'h0002, "R5 dsp drained");
      hr(1, A_ST, 16'h0002, "R5 host empty again");
      cmp("R7 d_irq low", {15'd0, d_irq}, 16'd0);

      // R6: overrun
      hw(1, A_TX, 16'h1111);
      hw(1, A_TX, 16'h2222);
      hr(1, A_ST, 16'h0004, "R6 overrun set");
      dr(1, A_RX, 16'h1111, "R6 first word kept");
      hr(1, A_ST, 16'h0006, "R6 overrun sticky");
      hw(1, A_ST, 16'h0004);
      hr(1, A_ST, 16'h0002, "R6 overrun cleared");

      // R8: read while empty
      dr(1, A_RX, 16'h1111, "R8 held word");
      dr(1, A_ST, 16'h0002, "R8 dsp flags");
      hr(1, A_ST, 16'h0002, "R8 host flags");

      // R7 / R10: dsp -> host with interrupt masked then enabled
      dw(1, A_TX, 16'h7777);
      idle();
      cmp("R7 masked", {15'd0, h_irq}, 16'd0);
      hr(1, A_ST, 16'h0003, "R10 host tx still empty");
      hw(1, A_CT, 16'h0001);
      idle();
      cmp("R7 enabled", {15'd0, h_irq}, 16'd1);
      hr(1, A_RX, 16'h7777, "R4 reverse word");
      idle();
      cmp("R7 cleared", {15'd0, h_irq}, 16'd0);

      // R10: both directions filled in one cycle
      cyc(1, 1, 1, A_TX, 16'h0101, 1, 1, 1, A_TX, 16'h0202);
      hr(1, A_ST, 16'h0001, "R10 host both full");
      dr(1, A_ST, 16'h0001, "R10 dsp both full");
      hr(1, A_RX, 16'h0202, "R10 host word");
      dr(1, A_RX, 16'h0101, "R10 dsp word");
      idle();
      idle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule